// File: doc/BRIEF.md
# Nickel-Unit Credit Accumulator

This block keeps the running credit of a vending controller. The credit is stored as a count of 5-cent units in a small register. The controlling sequencer sends one-cycle commands to change it: credit a coin of one of three sizes, refund a coin of one of three sizes, charge the 45-cent price, or clear the credit. A single ripple adder/subtractor does every arithmetic update. A selector feeds it one of four fixed operands (1, 2, 5 or 9 units). The operand is inverted and the carry-in is set to 1 whenever the command is not an add.

The block reports four threshold flags to the sequencer at all times. They show whether the credit is non-zero, whether a dime refund is possible (2 or more units), whether a quarter refund is possible (5 or more units), and whether the price is covered (9 or more units). Each flag except the non-zero flag is the sign bit of a fixed constant minus the balance. No general magnitude comparator is used. The flags follow the register directly, so they change in the same cycle as the balance.

Internally, a decoder sorts each cycle into one of four operation kinds. The kinds are HOLD, CLEAR, ADD and SUB. The transitions are: HOLD when no command is active; CLEAR when the clear command is active (this wins over all others); ADD when any credit command is active; SUB when any refund or charge command is active.

Top module: `credit_accum`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the balance becomes 0 and all four flags go low, whatever commands are present.
- R2: `cmd_add_nickel`, `cmd_add_dime` and `cmd_add_quarter` increase the balance by 1, 2 and 5 units respectively at the next clock edge.
- R3: `cmd_sub_nickel`, `cmd_sub_dime` and `cmd_sub_quarter` decrease the balance by 1, 2 and 5 units, and `cmd_sub_price` decreases it by 9 units, at the next clock edge.
- R4: `cmd_clear` sets the balance to 0 at the next edge, even when an add or subtract command is active in the same cycle.
- R5: In a cycle with no command active, the balance is unchanged.
- R6: `flag_nonzero` is 1 exactly when the balance is not 0.
- R7: `flag_dime` is 1 exactly when the balance is 2 units or more.
- R8: `flag_quarter` is 1 exactly when the balance is 5 units or more.
- R9: `flag_price` is 1 exactly when the balance is 9 units or more.
- R10: The flags are combinational on the balance. They reflect a new balance in the same cycle that the balance appears on `balance_o`.
- R11: Balances up to 13 units (for example 8 + 5) are held exactly, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_add_nickel | input | 1 | Credit 1 unit |
| cmd_add_dime | input | 1 | Credit 2 units |
| cmd_add_quarter | input | 1 | Credit 5 units |
| cmd_sub_nickel | input | 1 | Refund 1 unit |
| cmd_sub_dime | input | 1 | Refund 2 units |
| cmd_sub_quarter | input | 1 | Refund 5 units |
| cmd_sub_price | input | 1 | Charge 9 units |
| cmd_clear | input | 1 | Clear the balance |
| balance_o | output | 4 | Credit in 5-cent units |
| flag_nonzero | output | 1 | Balance > 0 |
| flag_dime | output | 1 | Balance >= 2 |
| flag_quarter | output | 1 | Balance >= 5 |
| flag_price | output | 1 | Balance >= 9 |

## Verification
Two functions can meet in one cycle: a clear and an arithmetic command, and a reset and an arithmetic command. The bench provokes the first by raising `cmd_clear` together with a quarter credit while the balance is non-zero. It provokes the second by holding a credit command high during a reset. In both cases a cycle-by-cycle reference model, which gives clear and reset priority, expects a zero balance with every flag low. The bench also walks the balance one unit at a time from 0 to 13 and back down, so each flag is judged on both sides of its threshold.

// File: rtl/credit_pkg.sv
package credit_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_ADD   = 2'd2,
        OP_SUB   = 2'd3
    } op_kind_e;

    localparam int UNITS_NICKEL  = 1;
    localparam int UNITS_DIME    = 2;
    localparam int UNITS_QUARTER = 5;
    localparam int UNITS_PRICE   = 9;

    localparam int NUM_LIMITS = 3;

endpackage

// File: rtl/credit_cmd_decode.sv
module credit_cmd_decode
    import credit_pkg::*;
#(
    parameter int BAL_W = 4
) (
    input  logic             add_n,
    input  logic             add_d,
    input  logic             add_q,
    input  logic             sub_n,
    input  logic             sub_d,
    input  logic             sub_q,
    input  logic             sub_p,
    input  logic             clr,
    output op_kind_e         op,
    output logic [BAL_W-1:0] operand
);

    localparam logic [BAL_W-1:0] K_NICKEL  = BAL_W'(UNITS_NICKEL);
    localparam logic [BAL_W-1:0] K_DIME    = BAL_W'(UNITS_DIME);
    localparam logic [BAL_W-1:0] K_QUARTER = BAL_W'(UNITS_QUARTER);
    localparam logic [BAL_W-1:0] K_PRICE   = BAL_W'(UNITS_PRICE);

    logic any_add;
    logic any_sub;

    always_comb begin
        any_add = add_n | add_d | add_q;
        any_sub = sub_n | sub_d | sub_q | sub_p;
        if (clr)          op = OP_CLEAR;
        else if (any_add) op = OP_ADD;
        else if (any_sub) op = OP_SUB;
        else              op = OP_HOLD;
    end

    always_comb begin
        if (add_q | sub_q)      operand = K_QUARTER;
        else if (sub_p)         operand = K_PRICE;
        else if (add_d | sub_d) operand = K_DIME;
        else if (add_n | sub_n) operand = K_NICKEL;
        else                    operand = '0;
    end

endmodule

// File: rtl/credit_addsub.sv
module credit_addsub #(
    parameter int BAL_W = 4
) (
    input  logic [BAL_W-1:0] a,
    input  logic [BAL_W-1:0] b,
    input  logic             sub,
    output logic [BAL_W-1:0] sum
);

    logic [BAL_W-1:0] carry;
    logic [BAL_W-1:0] b_eff;

    assign carry[0] = sub;

    for (genvar i = 0; i < BAL_W; i++) begin : g_bit
        assign b_eff[i] = b[i] ^ sub;
        assign sum[i]   = a[i] ^ b_eff[i] ^ carry[i];
        if (i < BAL_W - 1) begin : g_carry
            assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
        end
    end

endmodule

// File: rtl/credit_flags.sv
module credit_flags
    import credit_pkg::*;
#(
    parameter int BAL_W = 4
) (
    input  logic [BAL_W-1:0]      bal,
    output logic                  nonzero,
    output logic [NUM_LIMITS-1:0] at_least
);

    localparam int LIMIT_MINUS1 [NUM_LIMITS] = '{UNITS_DIME - 1, UNITS_QUARTER - 1, UNITS_PRICE - 1};

    function automatic logic neg_sign(input logic [BAL_W:0] k, input logic [BAL_W:0] v);
        logic [BAL_W:0] d;
        d = k - v;
        return d[BAL_W];
    endfunction

    assign nonzero = |bal;

    for (genvar t = 0; t < NUM_LIMITS; t++) begin : g_lim
        assign at_least[t] = neg_sign((BAL_W + 1)'(LIMIT_MINUS1[t]), {1'b0, bal});
    end

endmodule

// File: rtl/credit_accum.sv
module credit_accum
    import credit_pkg::*;
#(
    parameter int BAL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_add_nickel,
    input  logic             cmd_add_dime,
    input  logic             cmd_add_quarter,
    input  logic             cmd_sub_nickel,
    input  logic             cmd_sub_dime,
    input  logic             cmd_sub_quarter,
    input  logic             cmd_sub_price,
    input  logic             cmd_clear,
    output logic [BAL_W-1:0] balance_o,
    output logic             flag_nonzero,
    output logic             flag_dime,
    output logic             flag_quarter,
    output logic             flag_price
);

    op_kind_e              op;
    logic [BAL_W-1:0]      operand;
    logic [BAL_W-1:0]      bal_q;
    logic [BAL_W-1:0]      next_sum;
    logic [NUM_LIMITS-1:0] at_least;

    credit_cmd_decode #(.BAL_W(BAL_W)) u_dec (
        .add_n   (cmd_add_nickel),
        .add_d   (cmd_add_dime),
        .add_q   (cmd_add_quarter),
        .sub_n   (cmd_sub_nickel),
        .sub_d   (cmd_sub_dime),
        .sub_q   (cmd_sub_quarter),
        .sub_p   (cmd_sub_price),
        .clr     (cmd_clear),
        .op      (op),
        .operand (operand)
    );

    credit_addsub #(.BAL_W(BAL_W)) u_alu (
        .a   (bal_q),
        .b   (operand),
        .sub (op != OP_ADD),
        .sum (next_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bal_q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR:       bal_q <= '0;
                OP_ADD, OP_SUB: bal_q <= next_sum;
                default:        bal_q <= bal_q;
            endcase
        end
    end

    credit_flags #(.BAL_W(BAL_W)) u_flags (
        .bal      (bal_q),
        .nonzero  (flag_nonzero),
        .at_least (at_least)
    );

    always_comb begin
        balance_o    = bal_q;
        flag_dime    = at_least[0];
        flag_quarter = at_least[1];
        flag_price   = at_least[2];
    end

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (balance_o == '0)); // R1
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        cmd_clear |=> (balance_o == '0)); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(balance_o)); // R5
    AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADD) |=> (balance_o > $past(balance_o))); // R11
    AST_SUB_DROPS: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUB) |=> (balance_o < $past(balance_o))); // R3
    AST_PRICE_NEST: assert property (@(posedge clk) disable iff (rst)
        flag_price |-> (flag_quarter && flag_dime)); // R9
    AST_DIME_NEST: assert property (@(posedge clk) disable iff (rst)
        flag_dime |-> flag_nonzero); // R7

endmodule

// File: tb/sim_credit_accum.sv
module sim_credit_accum;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cmd = '0;  // {clear, sub_p, sub_q, sub_d, sub_n, add_q, add_d, add_n}
    logic [3:0] bal;
    logic       f_nz, f_d, f_q, f_p;
    int         checks = 0;
    int         errors = 0;
    int         model  = 0;

    always #4 clk = ~clk;

    credit_accum u0 (
        .clk             (clk),
        .rst             (rst),
        .cmd_add_nickel  (cmd[0]),
        .cmd_add_dime    (cmd[1]),
        .cmd_add_quarter (cmd[2]),
        .cmd_sub_nickel  (cmd[3]),
        .cmd_sub_dime    (cmd[4]),
        .cmd_sub_quarter (cmd[5]),
        .cmd_sub_price   (cmd[6]),
        .cmd_clear       (cmd[7]),
        .balance_o       (bal),
        .flag_nonzero    (f_nz),
        .flag_dime       (f_d),
        .flag_quarter    (f_q),
        .flag_price      (f_p)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, int'(bal), model);
        chk("R6/R10 nonzero flag", int'(f_nz), int'(model > 0));
        chk("R7/R10 dime flag", int'(f_d), int'(model >= 2));
        chk("R8/R10 quarter flag", int'(f_q), int'(model >= 5));
        chk("R9/R10 price flag", int'(f_p), int'(model >= 9));
    endtask

    task automatic step(input logic [7:0] c, input logic r, input string req);
        @(negedge clk);
        cmd = c;
        rst = r;
        @(posedge clk);
        if (r || c[7]) model = 0;
        else if (c[2]) model += 5;
        else if (c[1]) model += 2;
        else if (c[0]) model += 1;
        else if (c[5]) model -= 5;
        else if (c[6]) model -= 9;
        else if (c[4]) model -= 2;
        else if (c[3]) model -= 1;
        #2;
        compare_all(req);
        @(negedge clk);
        cmd = '0;
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(8'h00, 1'b1, "R1 reset");
        step(8'h00, 1'b1, "R1 reset held");
        step(8'h01, 1'b0, "R2 add nickel");
        step(8'h02, 1'b0, "R2 add dime");
        step(8'h04, 1'b0, "R2 add quarter");
        step(8'h04, 1'b0, "R11 reach 13");
        step(8'h00, 1'b0, "R5 idle hold");
        step(8'h00, 1'b0, "R5 idle hold again");
        step(8'h40, 1'b0, "R3 charge price");
        step(8'h08, 1'b0, "R3 refund nickel");
        step(8'h10, 1'b0, "R3 refund dime");
        step(8'h08, 1'b0, "R3 refund nickel to zero");
        step(8'h04, 1'b0, "R2 add quarter");
        step(8'h20, 1'b0, "R3 refund quarter");
        step(8'h04, 1'b0, "R2 add quarter");
        step(8'h84, 1'b0, "R4 clear beats add");
        step(8'h04, 1'b0, "R2 add quarter");
        step(8'h04, 1'b0, "R2 add quarter");
        step(8'hA0, 1'b0, "R4 clear beats refund");
        step(8'h04, 1'b0, "R2 add quarter");
        step(8'h04, 1'b1, "R1 reset beats add");
        for (int i = 0; i < 13; i++) step(8'h01, 1'b0, "R2/R11 nickel walk up");
        for (int i = 0; i < 13; i++) step(8'h08, 1'b0, "R3 nickel walk down");
        step(8'h02, 1'b0, "R2 add dime");
        step(8'h80, 1'b0, "R4 clear alone");
        step(8'h00, 1'b0, "R5 idle at zero");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule